// File: doc/BRIEF.md
# Serial-to-Byte Frame Aligner

The block takes a one-bit serial stream, clocked once per bit, and turns it into 8-bit parallel words. A byte strobe pulses once every eight bit clocks to mark each new word. Bits are packed most significant bit first: the earliest bit of a word lands in bit 7. The block also contains a frame hunt engine. When armed, it looks for the SONET framing pattern at every bit position. That pattern is three A1 bytes (0xF6) followed by three A2 bytes (0x28), 48 bits in all. When the hunt finds it, the engine moves the byte boundary so that the framing bytes and all later bytes come out whole.

The hunt is started and stopped through a control input, `oof_n`. Only its falling edges matter. What a falling edge does is set by `frm_dis`. With `frm_dis` low, the edge starts a hunt. With `frm_dis` high, the edge cancels any hunt in progress and leaves the boundary where it was. While a hunt runs, `byte_valid` is held low. When the pattern is found, `frame_det` is raised for one byte period, and the engine disarms itself so that the boundary stays locked. Both `oof_n` and `frm_dis` are brought into the bit clock domain by two-flop synchronizers, so a hunt takes effect two bit clocks after the edge.

The hunt controller has four states and the following transitions:
- IDLE: not hunting. Goes to HUNT on an arming edge.
- HUNT: searching. On a pattern match it goes to PEND if the match lands on a strobe cycle, and to SKIP otherwise.
- SKIP: waits for the strobe that presents the last A2 byte, then goes to PEND.
- PEND: on the next strobe it raises `frame_det` and returns to IDLE.

An arming edge sends any state to HUNT. A cancelling edge sends any state to IDLE.

Top module: `sonet_byte_aligner`

## Requirements
- R1: After reset, the block is not hunting: `byte_valid`=1, `frame_det`=0 and `byte_out`=0. The boundary offset is zero, so the first strobe, 8 bit clocks after reset release, presents the 8 bits shifted in on those clocks.
- R2: `byte_stb` is high for exactly one bit clock in every eight. In the cycle it is high, `byte_out` holds 8 consecutive serial bits, the earliest in bit 7.
- R3: A falling edge on `oof_n` while `frm_dis` is low starts a hunt. `byte_valid` goes low within 3 bit clocks of the edge.
- R4: While hunting, the pattern F6 F6 F6 28 28 28 is recognised whatever its phase relative to the current byte boundary.
- R5: After a match, every word presented while not hunting is aligned to the frame. Its last bit is a whole multiple of 8 bits after the last pattern bit.
- R6: `frame_det` rises on exactly one strobe per detection, namely the strobe that presents the first word after the last A2 byte. It then stays high until the next strobe.
- R7: After a detection the hunt is off. A later pattern at a different phase neither moves the boundary nor raises `frame_det`.
- R8: A falling edge on `oof_n` while `frm_dis` is high ends a hunt. `byte_valid` returns high, the boundary keeps its previous value, and no `frame_det` follows.
- R9: `byte_valid` stays low for the whole time a hunt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial data, one bit per clock |
| oof_n | input | 1 | Hunt control; falling edges act |
| frm_dis | input | 1 | Selects cancel (1) or arm (0) for an `oof_n` falling edge |
| byte_out | output | 8 | Parallel word, MSB received first |
| byte_stb | output | 1 | One-clock strobe marking a new word |
| byte_valid | output | 1 | Low while a hunt is running |
| frame_det | output | 1 | One-byte-period pulse after a detection |

## Verification
The hardest case to reach from the ports is a pattern whose last bit falls at each of the eight possible phases of the free-running byte counter. This matters most for the phase where the match coincides with a strobe: there the new offset must already apply to the word emitted on that same edge. The bench keeps its own count of bits since reset. Before each framed burst it computes how many prefix bits to send so that the pattern ends at the phase a table entry asks for, and it walks all eight phases. Cancellation and the one-shot behaviour are then shown by sending a pattern three bits off the locked boundary, followed by byte-aligned data that would read rotated if the boundary had moved.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SKIP,
        ST_PEND
    } hunt_st_e;

    localparam logic [7:0] A1_MARK = 8'hF6;
    localparam logic [7:0] A2_MARK = 8'h28;

endpackage

// File: rtl/sba_edge_sync.sv
module sba_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic oof_n,
    input  logic frm_dis,
    output logic fall,
    output logic dis_s
);
    logic oof_m, oof_s, oof_d;
    logic dis_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oof_m <= 1'b1;
            oof_s <= 1'b1;
            oof_d <= 1'b1;
            dis_m <= 1'b0;
            dis_s <= 1'b0;
        end else begin
            oof_m <= oof_n;
            oof_s <= oof_m;
            oof_d <= oof_s;
            dis_m <= frm_dis;
            dis_s <= dis_m;
        end
    end

    assign fall = oof_d & ~oof_s;

endmodule

// File: rtl/sba_slicer.sv
module sba_slicer #(
    parameter int W     = 8,
    parameter int WIN_W = 48,
    parameter logic [WIN_W-1:0] PAT = '0,
    localparam int OFF_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic [OFF_W-1:0] off_sel,
    output logic [OFF_W-1:0] cnt,
    output logic             at_last,
    output logic             match,
    output logic [W-1:0]     byte_out,
    output logic             byte_stb
);
    logic [WIN_W-2:0] win;
    logic [WIN_W-1:0] win_full;

    assign win_full = {win, ser_in};
    assign at_last  = (cnt == OFF_W'(W - 1));
    assign match    = (win_full == PAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            win      <= '0;
            byte_out <= '0;
            byte_stb <= 1'b0;
        end else begin
            cnt      <= at_last ? '0 : cnt + 1'b1;
            win      <= win_full[WIN_W-2:0];
            byte_stb <= at_last;
            if (at_last)
                byte_out <= win_full[off_sel +: W];
        end
    end

    // The strobe is never two clocks wide.
    p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);

    // A strobe means the counter has just wrapped.
    p_stb_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> (cnt == '0));

endmodule

// File: rtl/sba_hunt_fsm.sv
module sba_hunt_fsm
    import sba_pkg::*;
#(
    parameter int W = 8,
    localparam int OFF_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             dis_s,
    input  logic             match,
    input  logic             at_last,
    input  logic [OFF_W-1:0] cnt,
    output logic [OFF_W-1:0] off_nxt,
    output logic             hunting,
    output logic             frame_det
);
    hunt_st_e         st_q, st_n;
    logic [OFF_W-1:0] off_q;

    always_comb begin
        st_n    = st_q;
        off_nxt = off_q;
        unique case (st_q)
            ST_IDLE: ;
            ST_HUNT: if (match) begin
                off_nxt = OFF_W'(W - 1) - cnt;
                st_n    = at_last ? ST_PEND : ST_SKIP;
            end
            ST_SKIP: if (at_last) st_n = ST_PEND;
            ST_PEND: if (at_last) st_n = ST_IDLE;
        endcase
        if (fall) begin
            off_nxt = off_q;
            st_n    = dis_s ? ST_IDLE : ST_HUNT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            off_q <= '0;
        end else begin
            st_q  <= st_n;
            off_q <= off_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            frame_det <= 1'b0;
        else if (at_last)
            frame_det <= (st_q == ST_PEND) && !fall;
    end

    assign hunting = (st_q == ST_HUNT);

    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !dis_s) |=> (st_q == ST_HUNT));

    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && dis_s) |=> (st_q == ST_IDLE && $stable(off_q)));

    p_leave_hunt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT && match && !fall) |=> (st_q != ST_HUNT));

    p_offset_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_HUNT) |=> $stable(off_q));

    p_det_on_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_det) |-> ($past(at_last) && st_q == ST_IDLE));

endmodule

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner #(
    parameter int W    = 8,
    parameter int N_A1 = 3,
    parameter int N_A2 = 3,
    parameter logic [W-1:0] MARK_A1 = W'(sba_pkg::A1_MARK),
    parameter logic [W-1:0] MARK_A2 = W'(sba_pkg::A2_MARK)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         oof_n,
    input  logic         frm_dis,
    output logic [W-1:0] byte_out,
    output logic         byte_stb,
    output logic         byte_valid,
    output logic         frame_det
);
    localparam int OFF_W = $clog2(W);
    localparam int WIN_W = W * (N_A1 + N_A2);
    localparam logic [WIN_W-1:0] FRAME_PAT = {{N_A1{MARK_A1}}, {N_A2{MARK_A2}}};

    logic             fall, dis_s, match, at_last, hunting;
    logic [OFF_W-1:0] cnt, off_nxt;

    sba_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .oof_n   (oof_n),
        .frm_dis (frm_dis),
        .fall    (fall),
        .dis_s   (dis_s)
    );

    sba_slicer #(.W(W), .WIN_W(WIN_W), .PAT(FRAME_PAT)) u_slice (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .off_sel  (off_nxt),
        .cnt      (cnt),
        .at_last  (at_last),
        .match    (match),
        .byte_out (byte_out),
        .byte_stb (byte_stb)
    );

    sba_hunt_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .dis_s     (dis_s),
        .match     (match),
        .at_last   (at_last),
        .cnt       (cnt),
        .off_nxt   (off_nxt),
        .hunting   (hunting),
        .frame_det (frame_det)
    );

    assign byte_valid = ~hunting;

    // Valid stays low for as long as the hunt runs.
    p_valid_hunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !fall && !match) |=> !byte_valid);

    // A detection pulse never appears while hunting.
    p_det_not_hunting_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_det) |-> byte_valid);

endmodule

// File: tb/sonet_byte_aligner_bench.sv
`timescale 1ns/1ps
module sonet_byte_aligner_bench;

    localparam logic [47:0] PAT = {{3{8'hF6}}, {3{8'h28}}};
    localparam int NV = 8;
    // Each entry: {end phase of the pattern (bits mod 8), first payload byte (expected at the detection strobe), second payload byte}
    localparam logic [23:0] VEC [NV] = '{
        {8'd3, 8'hC3, 8'h11}, {8'd0, 8'h5A, 8'h96},
        {8'd5, 8'h01, 8'hFE}, {8'd7, 8'h80, 8'h7F},
        {8'd1, 8'h3C, 8'hE1}, {8'd6, 8'h99, 8'h24},
        {8'd2, 8'hAB, 8'hCD}, {8'd4, 8'h0F, 8'hF0}
    };

    logic       clk = 1'b0;
    logic       rst_n, ser_in, oof_n, frm_dis;
    logic [7:0] byte_out;
    logic       byte_stb, byte_valid, frame_det;

    int checks = 0, errors = 0;
    logic [63:0] sh = '0;
    int gbit = 0, exp_ph = 0, det_due = -1, det_cnt = 0;
    logic [7:0] det_word = '0;
    bit hunt_f = 0, done = 0;

    always #2 clk = ~clk;

    sonet_byte_aligner u_sonet_byte_aligner (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .oof_n(oof_n),
        .frm_dis(frm_dis), .byte_out(byte_out), .byte_stb(byte_stb),
        .byte_valid(byte_valid), .frame_det(frame_det)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic monitor();
        chk("R2 strobe cadence", longint'(byte_stb), longint'(gbit % 8 == 0));
        if (byte_stb) begin
            chk("R6 frame_det at strobe", longint'(frame_det), longint'(gbit == det_due));
            if (frame_det) begin
                det_cnt++;
                det_word = byte_out;
            end
            if (byte_valid && !hunt_f) begin
                int off = (((gbit - exp_ph) % 8) + 8) % 8;
                chk("R5 aligned word", longint'(byte_out), longint'((sh >> off) & 64'hFF));
            end
        end
    endtask

    task automatic tick(input logic b);
        ser_in = b;
        sh = {sh[62:0], b};
        gbit++;
        @(negedge clk);
        monitor();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) tick(v[i]);
    endtask

    task automatic send_frame(input bit armed);
        for (int i = 47; i >= 1; i--) tick(PAT[i]);
        if (armed) begin
            exp_ph  = (gbit + 1) % 8;
            det_due = ((gbit + 1 + 15) / 8) * 8;
            hunt_f  = 0;
        end
        tick(PAT[0]);
    endtask

    task automatic send_pre(input int n);
        for (int i = 0; i < n; i++) tick(i[0]);
    endtask

    task automatic arm();
        hunt_f = 1;
        frm_dis = 1'b0;
        oof_n = 1'b0;
        tick(1'b0);
        tick(1'b0);
        tick(1'b0);
        oof_n = 1'b1;
        tick(1'b0);
        chk("R3 R9 valid low once hunting", longint'(byte_valid), 0);
    endtask

    // Pattern ending (3 + locked phase) mod 8, then bytes aligned to the locked boundary.
    task automatic misaligned_burst();
        int want = (exp_ph + 3) % 8;
        send_pre(((want - gbit - 48) % 8 + 16) % 8 + 8);
        send_frame(1'b0);
        send_pre(((exp_ph - gbit) % 8 + 8) % 8);
        for (int i = 0; i < 4; i++) send_byte(8'h5A);
    endtask

    initial begin
        rst_n = 1'b0; ser_in = 1'b0; oof_n = 1'b1; frm_dis = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 reset valid", longint'(byte_valid), 1);
        chk("R1 reset frame_det", longint'(frame_det), 0);
        chk("R1 reset strobe", longint'(byte_stb), 0);
        chk("R1 reset byte_out", longint'(byte_out), 0);
        rst_n = 1'b1;
        send_byte(8'hA7);
        chk("R1 first word offset zero", longint'(byte_out), 64'hA7);
        chk("R1 first strobe", longint'(byte_stb), 1);
        send_byte(8'h3D);

        // R4 R5 R6 R9: table of end phases, all eight covered
        for (int v = 0; v < NV; v++) begin
            int r = int'(VEC[v][23:16]);
            det_cnt = 0;
            arm();
            send_pre(((r - gbit - 48) % 8 + 16) % 8 + 8);
            send_frame(1'b1);
            send_byte(VEC[v][15:8]);
            send_byte(VEC[v][7:0]);
            send_pre(16);
            chk("R4 phase found", longint'(exp_ph), longint'(r));
            chk("R6 one detection", longint'(det_cnt), 1);
            chk("R5 payload at detection", longint'(det_word), longint'(VEC[v][15:8]));
        end

        // R7: after lock an unarmed, misaligned pattern changes nothing
        det_cnt = 0;
        misaligned_burst();
        chk("R7 no detection when idle", longint'(det_cnt), 0);

        // R8: cancel a running hunt, boundary kept
        det_cnt = 0;
        arm();
        send_pre(3);
        frm_dis = 1'b1;
        oof_n = 1'b0;
        hunt_f = 0;
        tick(1'b0);
        send_pre(3);
        frm_dis = 1'b0;
        oof_n = 1'b1;
        tick(1'b0);
        chk("R8 valid back after cancel", longint'(byte_valid), 1);
        misaligned_burst();
        chk("R8 no detection after cancel", longint'(det_cnt), 0);
        chk("R9 valid stays high when idle", longint'(byte_valid), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule